// File: doc/BRIEF.md
# Supply Fault Protection Sequencer

This block is the digital supervisor of a switching power controller. It takes comparator flags for the supply rail and the fault monitors, and it decides when the PWM stage may run. A supply turn-on and turn-off pair with hysteresis gates normal operation. Four protections are debounced, each by its own counter: feedback stuck high (open loop), supply over-voltage, a mild over-temperature warning and a severe over-temperature alarm. The two temperature debounce windows grow longer while the light-load flag is high.

Each protection either latches the controller off or starts an auto-restart. An auto-restart holds PWM off until the supply sinks below the turn-off level. It then enables a discharge path that pulls the rail down to a lower floor, and only then may the rail recharge and start again. A latch-off holds until the supply collapses below a release level. A cause register shows which protections tripped most recently. All debounce windows are parameters counted in clock cycles.

Top module: `sfp_sequencer`

## Requirements
- R1: During and right after reset, pwm_en, latched and discharge_en are 0 and fault_cause is 0.
- R2: From the off state, pwm_en rises at the first clock edge that sees vdd_ge_start high. It stays high while vdd_ge_stop is high, even with vdd_ge_start low. It falls at the first edge that sees vdd_ge_stop low without a pending fault, and in that case neither latched nor discharge_en is asserted.
- R3: With fb_open high for OLP_CYC consecutive edges while running, pwm_en falls at the OLP_CYC-th edge. With OLP_LATCH=0 this is an auto-restart fault, and with OLP_LATCH=1 it latches.
- R4: A debounce count returns to zero when its condition drops before expiry, so a new full window is needed to trip.
- R5: With vdd_over high for OVP_CYC consecutive edges while running, pwm_en falls at the OVP_CYC-th edge as an auto-restart fault.
- R6: temp_warn latches the block off after OTW_NORM_CYC edges with light_load low, or after OTW_LIGHT_CYC edges with light_load high.
- R7: temp_crit latches the block off after OTC_NORM_CYC edges with light_load low, or after OTC_LIGHT_CYC edges with light_load high.
- R8: After an auto-restart fault, pwm_en and discharge_en stay low while vdd_ge_stop is high. discharge_en rises at the first edge that sees vdd_ge_stop low and falls at the first edge that sees vdd_ge_floor low. After that, the block restarts as in R2.
- R9: Once latched, latched stays 1 and pwm_en and discharge_en stay 0 until an edge sees vdd_ge_release low. It then clears, and the block restarts as in R2.
- R10: When a latch-class fault and an auto-restart fault expire at the same edge, the latch-off wins.
- R11: fault_cause bit 0 is open loop, bit 1 is over-voltage, bit 2 is mild temperature and bit 3 is severe temperature. At each trip it loads every fault that expired at that edge, and otherwise it holds, including across restarts.
- R12: At most one of pwm_en, latched and discharge_en is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vdd_ge_start | input | 1 | Supply is at or above the turn-on level |
| vdd_ge_stop | input | 1 | Supply is at or above the turn-off level |
| vdd_ge_floor | input | 1 | Supply is at or above the discharge floor |
| vdd_ge_release | input | 1 | Supply is at or above the latch release level |
| vdd_over | input | 1 | Supply is above the over-voltage level |
| fb_open | input | 1 | Feedback is above the open-loop level |
| temp_warn | input | 1 | Thermistor voltage is below the mild threshold |
| temp_crit | input | 1 | Thermistor voltage is below the severe threshold |
| light_load | input | 1 | Controller is in light-load operation |
| pwm_en | output | 1 | PWM stage may switch |
| latched | output | 1 | Controller is latched off |
| discharge_en | output | 1 | Supply discharge path is enabled |
| fault_cause | output | 4 | Faults that expired at the most recent trip |

## Verification
The bench builds the block with short windows: OLP_CYC=20, OVP_CYC=6, OTW_NORM_CYC=20, OTW_LIGHT_CYC=50, OTC_NORM_CYC=5, OTC_LIGHT_CYC=12, and OLP_LATCH=0. With these values every debounce expiry can be checked to the exact edge within a few hundred cycles. The equal open-loop and mild-temperature windows let both faults expire on the same edge, which exercises the latch-over-restart priority. The light-load windows are more than twice the normal ones, so a check one edge before the normal expiry shows that the longer window is in use.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int NUM_FAULTS = 4;

    // fault index, also the bit position in fault_cause
    localparam int FLT_OLP  = 0;
    localparam int FLT_OVP  = 1;
    localparam int FLT_OTW  = 2;
    localparam int FLT_OTC  = 3;

    typedef enum logic [2:0] {
        ST_OFF,     // waiting for supply to reach start level
        ST_RUN,     // PWM allowed
        ST_WAIT,    // auto-restart fault, waiting for supply to drop below stop
        ST_DRAIN,   // discharging supply down to floor
        ST_LATCH    // latched off until release level
    } seq_state_e;

    typedef struct packed {
        seq_state_e             state;
        logic [NUM_FAULTS-1:0]  cause;
    } seq_regs_t;

endpackage

// File: rtl/sfp_debounce.sv
module sfp_debounce #(
    parameter int unsigned LIM_NORM  = 16,
    parameter int unsigned LIM_LIGHT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cond,
    input  logic light,
    output logic expired
);
    localparam int unsigned LIM_MAX = (LIM_LIGHT > LIM_NORM) ? LIM_LIGHT : LIM_NORM;
    localparam int          CW      = $clog2(LIM_MAX + 1);
    localparam logic [CW-1:0] TOP_N = CW'(LIM_NORM - 1);
    localparam logic [CW-1:0] TOP_L = CW'(LIM_LIGHT - 1);
    localparam logic [CW-1:0] TOP_M = CW'(LIM_MAX - 1);

    logic [CW-1:0] cnt_d, cnt_q, lim_m1;
    logic          live;

    always_comb begin
        live    = arm && cond;
        lim_m1  = light ? TOP_L : TOP_N;
        expired = live && (cnt_q >= lim_m1);
        cnt_d   = '0;
        if (live) begin
            cnt_d = (cnt_q != TOP_M) ? cnt_q + 1'b1 : cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sfp_trip_classify.sv
module sfp_trip_classify
    import sfp_pkg::*;
#(
    parameter bit OLP_LATCH = 1'b0
) (
    input  logic [NUM_FAULTS-1:0] expired,
    output logic                  latch_trip,
    output logic                  restart_trip
);
    logic [NUM_FAULTS-1:0] latch_mask;

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_mask
        if (i == FLT_OLP) begin : g_olp
            assign latch_mask[i] = OLP_LATCH;
        end else if (i == FLT_OVP) begin : g_ovp
            assign latch_mask[i] = 1'b0;
        end else begin : g_temp
            assign latch_mask[i] = 1'b1;
        end
    end

    always_comb begin
        latch_trip   = |(expired & latch_mask);
        restart_trip = |(expired & ~latch_mask);
    end

endmodule

// File: rtl/sfp_lockout_fsm.sv
module sfp_lockout_fsm
    import sfp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vdd_ge_start,
    input  logic                  vdd_ge_stop,
    input  logic                  vdd_ge_floor,
    input  logic                  vdd_ge_release,
    input  logic [NUM_FAULTS-1:0] expired,
    input  logic                  latch_trip,
    input  logic                  restart_trip,
    output logic                  arm,
    output logic                  pwm_en,
    output logic                  latched,
    output logic                  discharge_en,
    output logic [NUM_FAULTS-1:0] fault_cause
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_OFF: begin
                if (vdd_ge_start) r_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (latch_trip) begin
                    r_d.state = ST_LATCH;
                    r_d.cause = expired;
                end else if (restart_trip) begin
                    r_d.state = ST_WAIT;
                    r_d.cause = expired;
                end else if (!vdd_ge_stop) begin
                    r_d.state = ST_OFF;
                end
            end
            ST_WAIT: begin
                if (!vdd_ge_stop) r_d.state = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!vdd_ge_floor) r_d.state = ST_OFF;
            end
            ST_LATCH: begin
                if (!vdd_ge_release) r_d.state = ST_OFF;
            end
            default: r_d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;
            r_q.cause <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        arm          = (r_q.state == ST_RUN);
        pwm_en       = (r_q.state == ST_RUN);
        latched      = (r_q.state == ST_LATCH);
        discharge_en = (r_q.state == ST_DRAIN);
        fault_cause  = r_q.cause;
    end

endmodule

// File: rtl/sfp_sequencer.sv
module sfp_sequencer
    import sfp_pkg::*;
#(
    parameter int unsigned OLP_CYC       = 55000,
    parameter int unsigned OVP_CYC       = 165,
    parameter int unsigned OTW_NORM_CYC  = 16000,
    parameter int unsigned OTW_LIGHT_CYC = 51000,
    parameter int unsigned OTC_NORM_CYC  = 185,
    parameter int unsigned OTC_LIGHT_CYC = 605,
    parameter bit          OLP_LATCH     = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vdd_ge_start,
    input  logic                  vdd_ge_stop,
    input  logic                  vdd_ge_floor,
    input  logic                  vdd_ge_release,
    input  logic                  vdd_over,
    input  logic                  fb_open,
    input  logic                  temp_warn,
    input  logic                  temp_crit,
    input  logic                  light_load,
    output logic                  pwm_en,
    output logic                  latched,
    output logic                  discharge_en,
    output logic [NUM_FAULTS-1:0] fault_cause
);
    localparam int unsigned LIM_N [NUM_FAULTS] = '{OLP_CYC, OVP_CYC, OTW_NORM_CYC,  OTC_NORM_CYC};
    localparam int unsigned LIM_L [NUM_FAULTS] = '{OLP_CYC, OVP_CYC, OTW_LIGHT_CYC, OTC_LIGHT_CYC};

    logic [NUM_FAULTS-1:0] cond;
    logic [NUM_FAULTS-1:0] expired;
    logic                  arm;
    logic                  latch_trip;
    logic                  restart_trip;

    always_comb begin
        cond          = '0;
        cond[FLT_OLP] = fb_open;
        cond[FLT_OVP] = vdd_over;
        cond[FLT_OTW] = temp_warn;
        cond[FLT_OTC] = temp_crit;
    end

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_deb
        sfp_debounce #(
            .LIM_NORM  (LIM_N[i]),
            .LIM_LIGHT (LIM_L[i])
        ) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (arm),
            .cond    (cond[i]),
            .light   (light_load),
            .expired (expired[i])
        );
    end

    sfp_trip_classify #(.OLP_LATCH(OLP_LATCH)) u_cls (
        .expired      (expired),
        .latch_trip   (latch_trip),
        .restart_trip (restart_trip)
    );

    sfp_lockout_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .vdd_ge_start   (vdd_ge_start),
        .vdd_ge_stop    (vdd_ge_stop),
        .vdd_ge_floor   (vdd_ge_floor),
        .vdd_ge_release (vdd_ge_release),
        .expired        (expired),
        .latch_trip     (latch_trip),
        .restart_trip   (restart_trip),
        .arm            (arm),
        .pwm_en         (pwm_en),
        .latched        (latched),
        .discharge_en   (discharge_en),
        .fault_cause    (fault_cause)
    );

endmodule

// File: rtl/sfp_sequencer_chk.sv
module sfp_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_ge_start,
    input logic       vdd_ge_stop,
    input logic       vdd_ge_floor,
    input logic       vdd_ge_release,
    input logic       pwm_en,
    input logic       latched,
    input logic       discharge_en,
    input logic [3:0] fault_cause
);
    // R12
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pwm_en, latched, discharge_en}));

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_en) |-> $past(vdd_ge_start));

    // R9
    latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latched) |-> !$past(vdd_ge_release));

    // R8
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(discharge_en) |-> !$past(vdd_ge_floor));

    // R8
    drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(discharge_en) |-> (!$past(vdd_ge_stop) && !$past(pwm_en)));

    // R11
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_cause) |-> $fell(pwm_en));

endmodule

bind sfp_sequencer sfp_sequencer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .vdd_ge_start   (vdd_ge_start),
    .vdd_ge_stop    (vdd_ge_stop),
    .vdd_ge_floor   (vdd_ge_floor),
    .vdd_ge_release (vdd_ge_release),
    .pwm_en         (pwm_en),
    .latched        (latched),
    .discharge_en   (discharge_en),
    .fault_cause    (fault_cause)
);

// File: tb/sfp_sequencer_tb.sv
module sfp_sequencer_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  OLP_N = 20, OVP_N = 6, OTW_N = 20, OTW_L = 50, OTC_N = 5, OTC_L = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   v = 0;          // supply in tenths of a volt
    logic fb_open = 1'b0, temp_warn = 1'b0, temp_crit = 1'b0, light_load = 1'b0;
    logic pwm_en, latched, discharge_en;
    logic [3:0] fault_cause;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sfp_sequencer #(
        .OLP_CYC(OLP_N), .OVP_CYC(OVP_N),
        .OTW_NORM_CYC(OTW_N), .OTW_LIGHT_CYC(OTW_L),
        .OTC_NORM_CYC(OTC_N), .OTC_LIGHT_CYC(OTC_L),
        .OLP_LATCH(1'b0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .vdd_ge_start(v >= 165), .vdd_ge_stop(v >= 90),
        .vdd_ge_floor(v >= 65), .vdd_ge_release(v >= 40),
        .vdd_over(v >= 250), .fb_open(fb_open),
        .temp_warn(temp_warn), .temp_crit(temp_crit), .light_load(light_load),
        .pwm_en(pwm_en), .latched(latched), .discharge_en(discharge_en),
        .fault_cause(fault_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic outs(input string req, input logic p, input logic l, input logic d);
        chk(req, {29'd0, pwm_en, latched, discharge_en}, {29'd0, p, l, d});
    endtask

    task automatic set_fault(input int idx, input logic val);
        case (idx)
            0: fb_open = val;
            1: v = val ? 260 : 170;
            2: temp_warn = val;
            default: temp_crit = val;
        endcase
    endtask

    task automatic edge_chk();
        @(posedge clk); #1;
    endtask

    task automatic go_run(input string req);
        @(negedge clk); v = 170;
        edge_chk();
        outs(req, 1'b1, 1'b0, 1'b0);
    endtask

    // hold a fault for lim edges; pwm must survive lim-1 and drop on the lim-th
    task automatic hold_and_trip(input int idx, input int lim, input string req);
        @(negedge clk); set_fault(idx, 1'b1);
        repeat (lim - 1) @(posedge clk);
        #1 chk({req, " before expiry"}, {31'd0, pwm_en}, 32'd1);
        edge_chk();
        chk({req, " at expiry"}, {31'd0, pwm_en}, 32'd0);
        @(negedge clk); set_fault(idx, 1'b0);
    endtask

    task automatic restart_cycle(input string req);
        @(negedge clk); v = 120;
        repeat (3) @(posedge clk);
        #1 outs({req, " wait above stop"}, 1'b0, 1'b0, 1'b0);
        @(negedge clk); v = 80;
        edge_chk();
        outs({req, " drain on"}, 1'b0, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        #1 outs({req, " drain held"}, 1'b0, 1'b0, 1'b1);
        @(negedge clk); v = 60;
        edge_chk();
        outs({req, " drain off"}, 1'b0, 1'b0, 1'b0);
        go_run({req, " restart"});
    endtask

    task automatic latch_cycle(input string req);
        outs({req, " latched"}, 1'b0, 1'b1, 1'b0);
        @(negedge clk); v = 80;
        repeat (3) @(posedge clk);
        #1 outs({req, " below stop"}, 1'b0, 1'b1, 1'b0);
        @(negedge clk); v = 60;
        repeat (3) @(posedge clk);
        #1 outs({req, " below floor"}, 1'b0, 1'b1, 1'b0);
        @(negedge clk); v = 30;
        edge_chk();
        outs({req, " released"}, 1'b0, 1'b0, 1'b0);
        go_run({req, " restart"});
    endtask

    task automatic t_reset();
        #1 outs("R1 in reset", 1'b0, 1'b0, 1'b0);
        chk("R1 cause", {28'd0, fault_cause}, 32'd0);
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        edge_chk();
        outs("R1 after reset", 1'b0, 1'b0, 1'b0);
        chk("R1 cause after", {28'd0, fault_cause}, 32'd0);
    endtask

    task automatic t_uvlo();
        @(negedge clk); v = 120;
        repeat (3) @(posedge clk);
        #1 outs("R2 below start", 1'b0, 1'b0, 1'b0);
        go_run("R2 start");
        @(negedge clk); v = 120;
        repeat (3) @(posedge clk);
        #1 outs("R2 hysteresis", 1'b1, 1'b0, 1'b0);
        @(negedge clk); v = 80;
        edge_chk();
        outs("R2 uvlo stop", 1'b0, 1'b0, 1'b0);
        chk("R2 cause untouched", {28'd0, fault_cause}, 32'd0);
        go_run("R2 start again");
    endtask

    task automatic t_olp();
        @(negedge clk); fb_open = 1'b1;
        repeat (OLP_N - 1) @(posedge clk);
        @(negedge clk); fb_open = 1'b0;
        edge_chk();
        chk("R4 early clear", {31'd0, pwm_en}, 32'd1);
        hold_and_trip(0, OLP_N, "R3 open loop");
        outs("R3 restart class", 1'b0, 1'b0, 1'b0);
        chk("R11 cause olp", {28'd0, fault_cause}, 32'h1);
        restart_cycle("R8 olp");
        chk("R11 cause held", {28'd0, fault_cause}, 32'h1);
    endtask

    task automatic t_ovp();
        hold_and_trip(1, OVP_N, "R5 over-voltage");
        outs("R5 restart class", 1'b0, 1'b0, 1'b0);
        chk("R11 cause ovp", {28'd0, fault_cause}, 32'h2);
        restart_cycle("R8 ovp");
    endtask

    task automatic t_temp(input int idx, input int ln, input int ll, input string req);
        @(negedge clk); light_load = 1'b0;
        hold_and_trip(idx, ln, {req, " normal"});
        chk({req, " R11 cause"}, {28'd0, fault_cause}, 32'(1 << idx));
        latch_cycle({req, " R9"});
        @(negedge clk); light_load = 1'b1;
        hold_and_trip(idx, ll, {req, " light"});
        latch_cycle({req, " R9 light"});
        @(negedge clk); light_load = 1'b0;
    endtask

    task automatic t_prio();
        @(negedge clk); fb_open = 1'b1; temp_warn = 1'b1;
        repeat (OLP_N - 1) @(posedge clk);
        #1 chk("R10 before expiry", {31'd0, pwm_en}, 32'd1);
        edge_chk();
        @(negedge clk); fb_open = 1'b0; temp_warn = 1'b0;
        chk("R10 cause both", {28'd0, fault_cause}, 32'h5);
        latch_cycle("R10 latch wins");
    endtask

    initial begin
        t_reset();
        t_uvlo();
        t_olp();
        t_ovp();
        t_temp(2, OTW_N, OTW_L, "R6 mild temp");
        t_temp(3, OTC_N, OTC_L, "R7 severe temp");
        t_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule